// File: doc/BRIEF.md
# Interconnect Initiator Error Logger

This block sits beside one initiator agent of an on-chip interconnect and watches the agent's traffic. The traffic arrives as pre-decoded strobes: request accepted, response beat, last beat, in-band error response and target SError. Each strobe carries command, initiator/thread ID and request-info side-band values. The block keeps one transaction outstanding at a time and times it out when it stops making progress. It records the first error it sees in a 64-bit log word and raises a level interrupt toward the host.

A time-out puts the agent out of service, and it then refuses new requests. Software reads the log through a small register port. It recovers the agent with a soft-reset pulse: a 1 written to the control bit, then a 0. Later errors do not overwrite the first record. They set a multiple-error bit and add their sticky flags. For a time-out, the log also records whether the stalled transaction was a burst or a single read/write.

Top module: `ic_err_logger`

## Requirements
- R1: After reset the log reads all zero, `irq`, `flag_serr` and `flag_timeout` are 0 and `req_ready` is 1.
- R2: An in-band error strobe on an empty log records code 0x4 in bits [27:24] and the ID in bits [15:8]. It writes 0 to the command field [2:0], the request-info field [43:32], bit 30 and bits [60:48].
- R3: An SError strobe on an empty log records code 0x5, the command in [2:0], the ID in [15:8] and the request info in [43:32], with bit 30 = 0. It sets sticky bit 48 and `flag_serr`.
- R4: With `to_limit` = N > 0, a time-out is logged on the N-th rising edge after the last progress of an outstanding transaction, and not one edge earlier. Progress is the request's acceptance or a response beat. The record holds code 0x2, bit 30 = 1, sticky bit 49 (`flag_timeout`) and the command, ID and info of the stalled request. `to_limit` = 0 disables the time-out.
- R5: A time-out sets log bit 50 when the stalled request was a burst and leaves it 0 for a single read/write.
- R6: After a time-out `req_ready` stays 0 and requests are ignored until a soft reset.
- R7: While a record is held, any further error sets MULTI (bit 31), ORs its sticky flags into [60:48] and leaves the first record's other fields unchanged.
- R8: Errors in the same cycle are ranked time-out, then SError, then in-band. The highest-ranked one is recorded and bit 31 is set.
- R9: `irq` is 1 while the log holds a record. Soft reset means writing 1 to bit 0 at address 2 and later writing 0 there. The 1 holds the agent: `req_ready` is 0 and error strobes are ignored. The log stays intact. The 0 write clears the log and the agent, so `irq` is 0 and `req_ready` is 1 in the next cycle.
- R10: Read address 0 gives log [31:0], address 1 gives [63:32] and address 2 gives the control bit in bit 0. Writes to addresses 0 and 1 are ignored.
- R11: At most one transaction is outstanding. `req_ready` is 0 from acceptance until a response beat with `rsp_last` ends it, and no time-out follows a completed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the agent |
| req_burst | input | 1 | Offered request is a burst |
| ev_cmd | input | 3 | Command side-band for the current strobe |
| ev_id | input | 8 | Initiator/thread ID side-band |
| ev_info | input | 12 | Request-info side-band |
| rsp_beat | input | 1 | Response beat accepted |
| rsp_last | input | 1 | Beat is the last of the transaction |
| ev_inband | input | 1 | In-band error response strobe |
| ev_serr | input | 1 | Target SError strobe |
| to_limit | input | TO_W | Cycles without progress before a time-out, 0 = off |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_ready | output | 1 | Agent accepts a request |
| irq | output | 1 | Level interrupt, log holds a record |
| flag_serr | output | 1 | Sticky SError flag (log bit 48) |
| flag_timeout | output | 1 | Sticky time-out flag (log bit 49) |

## Verification
The bench builds the block with `TO_W` = 4, so the counter's full range fits in a short run. This lets it drive `to_limit` to both 6 and its top value 15 and observe the exact edge of the time-out. The small width also keeps the disabled setting (0) and beats that arrive one cycle before expiry cheap to cover. Error kinds, burst and single stalls, stacked and simultaneous errors, and the hold phase of the soft reset are all observed through the register port.

// File: rtl/ic_err_pkg.sv
package ic_err_pkg;
  localparam int CMD_W  = 3;
  localparam int ID_W   = 8;
  localparam int INFO_W = 12;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  localparam int FLAG_W = 13;

  localparam logic [3:0] CODE_TIMEOUT = 4'h2;
  localparam logic [3:0] CODE_INBAND  = 4'h4;
  localparam logic [3:0] CODE_SERR    = 4'h5;

  localparam int FL_SERR  = 0;
  localparam int FL_TOUT  = 1;
  localparam int FL_BURST = 2;

  localparam logic [ADDR_W-1:0] A_LOG_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOG_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  typedef struct packed {
    logic [2:0]        rsv_top;
    logic [FLAG_W-1:0] flags;
    logic [3:0]        rsv_info;
    logic [INFO_W-1:0] info;
    logic              multi;
    logic              secondary;
    logic [1:0]        rsv_code;
    logic [3:0]        code;
    logic [7:0]        rsv_id;
    logic [ID_W-1:0]   id;
    logic [4:0]        rsv_cmd;
    logic [CMD_W-1:0]  cmd;
  } err_log_t;
endpackage

// File: rtl/ic_err_wdog.sv
module ic_err_wdog
  import ic_err_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              clr,
  input  logic              req_valid,
  input  logic              req_burst,
  input  logic [CMD_W-1:0]  ev_cmd,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [INFO_W-1:0] ev_info,
  input  logic              rsp_beat,
  input  logic              rsp_last,
  input  logic [TO_W-1:0]   to_limit,
  output logic              ready,
  output logic              fire,
  output logic              fire_burst,
  output logic [CMD_W-1:0]  sv_cmd,
  output logic [ID_W-1:0]   sv_id,
  output logic [INFO_W-1:0] sv_info
);
  localparam logic [TO_W-1:0] ONE = {{(TO_W-1){1'b0}}, 1'b1};

  logic              busy_q, busy_d, burst_q, burst_d, oos_q, oos_d;
  logic [TO_W-1:0]   cnt_q, cnt_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [ID_W-1:0]   id_q;
  logic [INFO_W-1:0] info_q;
  logic              accept, run, cap_en;

  assign ready  = !oos_q && !hold && !busy_q;
  assign accept = req_valid && ready;
  assign run    = busy_q && !hold;
  assign fire   = run && !rsp_beat && (to_limit != '0) && (cnt_q == to_limit - ONE);
  assign cap_en = accept || clr;

  always_comb begin
    busy_d  = busy_q;
    burst_d = burst_q;
    oos_d   = oos_q;
    cnt_d   = cnt_q;
    if (clr) begin
      busy_d  = 1'b0;
      burst_d = 1'b0;
      oos_d   = 1'b0;
      cnt_d   = '0;
    end else if (accept) begin
      busy_d  = 1'b1;
      burst_d = req_burst;
      cnt_d   = '0;
    end else if (run) begin
      if (rsp_beat) begin
        cnt_d = '0;
        if (rsp_last) busy_d = 1'b0;
      end else if (fire) begin
        busy_d = 1'b0;
        oos_d  = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      oos_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      burst_q <= burst_d;
      oos_q   <= oos_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      id_q   <= '0;
      info_q <= '0;
    end else if (cap_en) begin
      cmd_q  <= clr ? '0 : ev_cmd;
      id_q   <= clr ? '0 : ev_id;
      info_q <= clr ? '0 : ev_info;
    end
  end

  assign fire_burst = burst_q;
  assign sv_cmd     = cmd_q;
  assign sv_id      = id_q;
  assign sv_info    = info_q;
endmodule

// File: rtl/ic_err_capture.sv
module ic_err_capture
  import ic_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              clr,
  input  logic              ev_inband,
  input  logic              ev_serr,
  input  logic [CMD_W-1:0]  ev_cmd,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [INFO_W-1:0] ev_info,
  input  logic              fire,
  input  logic              fire_burst,
  input  logic [CMD_W-1:0]  to_cmd,
  input  logic [ID_W-1:0]   to_id,
  input  logic [INFO_W-1:0] to_info,
  output err_log_t          log_q
);
  err_log_t   log_d;
  logic       inb, srr, any, held, log_en;
  logic [1:0] n_err;

  assign inb    = ev_inband && !hold;
  assign srr    = ev_serr && !hold;
  assign any    = inb || srr || fire;
  assign n_err  = {1'b0, inb} + {1'b0, srr} + {1'b0, fire};
  assign held   = (log_q.code != 4'h0);
  assign log_en = any || clr;

  always_comb begin
    log_d = log_q;
    if (clr) begin
      log_d = '0;
    end else if (any) begin
      if (!held) begin
        if (fire) begin
          log_d.code      = CODE_TIMEOUT;
          log_d.secondary = 1'b1;
          log_d.cmd       = to_cmd;
          log_d.id        = to_id;
          log_d.info      = to_info;
        end else if (srr) begin
          log_d.code      = CODE_SERR;
          log_d.secondary = 1'b0;
          log_d.cmd       = ev_cmd;
          log_d.id        = ev_id;
          log_d.info      = ev_info;
        end else begin
          log_d.code      = CODE_INBAND;
          log_d.secondary = 1'b0;
          log_d.cmd       = '0;
          log_d.id        = ev_id;
          log_d.info      = '0;
        end
        log_d.multi = (n_err > 2'd1);
      end else begin
        log_d.multi = 1'b1;
      end
      if (fire) begin
        log_d.flags[FL_TOUT]  = 1'b1;
        log_d.flags[FL_BURST] = fire_burst;
      end
      if (srr) log_d.flags[FL_SERR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      log_q <= '0;
    else if (log_en) log_q <= log_d;
  end
endmodule

// File: rtl/ic_err_regs.sv
module ic_err_regs
  import ic_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  err_log_t          log_q,
  output logic [REG_W-1:0]  rdata,
  output logic              soft_q,
  output logic              sw_clr
);
  logic ctrl_hit, soft_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:1];
  assign ctrl_hit     = we && (addr == A_CTRL);
  assign soft_d       = wdata[0];
  assign sw_clr       = ctrl_hit && !wdata[0] && soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        soft_q <= 1'b0;
    else if (ctrl_hit) soft_q <= soft_d;
  end

  always_comb begin
    case (addr)
      A_LOG_LO: rdata = log_q[REG_W-1:0];
      A_LOG_HI: rdata = log_q[2*REG_W-1:REG_W];
      A_CTRL:   rdata = {{(REG_W-1){1'b0}}, soft_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ic_err_logger.sv
module ic_err_logger
  import ic_err_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_burst,
  input  logic [CMD_W-1:0]  ev_cmd,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [INFO_W-1:0] ev_info,
  input  logic              rsp_beat,
  input  logic              rsp_last,
  input  logic              ev_inband,
  input  logic              ev_serr,
  input  logic [TO_W-1:0]   to_limit,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              req_ready,
  output logic              irq,
  output logic              flag_serr,
  output logic              flag_timeout
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              soft_q, sw_clr, fire, fire_burst;
  logic [CMD_W-1:0]  sv_cmd;
  logic [ID_W-1:0]   sv_id;
  logic [INFO_W-1:0] sv_info;
  err_log_t          log_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ic_err_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .log_q(log_q), .rdata(reg_rdata),
    .soft_q(soft_q), .sw_clr(sw_clr)
  );

  ic_err_wdog #(.TO_W(TO_W)) u_wdog (
    .clk(clk), .rst_n(rst_n_s), .hold(soft_q), .clr(sw_clr),
    .req_valid(req_valid), .req_burst(req_burst),
    .ev_cmd(ev_cmd), .ev_id(ev_id), .ev_info(ev_info),
    .rsp_beat(rsp_beat), .rsp_last(rsp_last), .to_limit(to_limit),
    .ready(req_ready), .fire(fire), .fire_burst(fire_burst),
    .sv_cmd(sv_cmd), .sv_id(sv_id), .sv_info(sv_info)
  );

  ic_err_capture u_cap (
    .clk(clk), .rst_n(rst_n_s), .hold(soft_q), .clr(sw_clr),
    .ev_inband(ev_inband), .ev_serr(ev_serr),
    .ev_cmd(ev_cmd), .ev_id(ev_id), .ev_info(ev_info),
    .fire(fire), .fire_burst(fire_burst),
    .to_cmd(sv_cmd), .to_id(sv_id), .to_info(sv_info),
    .log_q(log_q)
  );

  assign irq          = (log_q.code != 4'h0);
  assign flag_serr    = log_q.flags[FL_SERR];
  assign flag_timeout = log_q.flags[FL_TOUT];
endmodule

// File: rtl/ic_err_logger_chk.sv
module ic_err_logger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        irq,
  input logic        flag_timeout,
  input logic        soft_q,
  input logic        sw_clr,
  input logic [63:0] log_q
);
  // R6
  oos_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_timeout |-> !req_ready);

  // R7
  multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q[31] && !sw_clr) |=> log_q[31]);

  // R7
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sw_clr) |=> ($stable(log_q[27:0]) && $stable(log_q[43:32])));

  // R9
  clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !irq);

  // R9
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |-> !req_ready);

  // R4
  tout_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_timeout) |-> irq);
endmodule

bind ic_err_logger ic_err_logger_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .req_ready(req_ready), .irq(irq),
  .flag_timeout(flag_timeout), .soft_q(soft_q), .sw_clr(sw_clr),
  .log_q(log_q)
);

// File: tb/ic_err_logger_bench.sv
module ic_err_logger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 4;
  localparam int LIM = 6;
  localparam int NVEC = 6;
  // {kind[24:23], cmd[22:20], id[19:12], info[11:0]}; kind 0 in-band, 1 SError, 2 stall burst, 3 stall single
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {2'd0, 3'd3, 8'h13, 12'h012},
    {2'd1, 3'd1, 8'h42, 12'hABC},
    {2'd2, 3'd5, 8'h7E, 12'h3F0},
    {2'd3, 3'd2, 8'h05, 12'h801},
    {2'd0, 3'd7, 8'hFF, 12'hFFF},
    {2'd1, 3'd0, 8'h00, 12'h001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_burst, rsp_beat, rsp_last, ev_inband, ev_serr, reg_we;
  logic [2:0] ev_cmd;
  logic [7:0] ev_id;
  logic [11:0] ev_info;
  logic [TO_W-1:0] to_limit;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic req_ready, irq, flag_serr, flag_timeout;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lo, hi, lo0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ic_err_logger #(.TO_W(TO_W)) u_ic_err_logger (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
    .ev_cmd(ev_cmd), .ev_id(ev_id), .ev_info(ev_info),
    .rsp_beat(rsp_beat), .rsp_last(rsp_last), .ev_inband(ev_inband),
    .ev_serr(ev_serr), .to_limit(to_limit), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_ready(req_ready), .irq(irq), .flag_serr(flag_serr),
    .flag_timeout(flag_timeout)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic read_log(output logic [31:0] l, output logic [31:0] h);
    reg_addr = 2'd0; #1 l = reg_rdata;
    reg_addr = 2'd1; #1 h = reg_rdata;
    reg_addr = 2'd3;
  endtask

  task automatic soft_reset();
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1; step();
    reg_wdata = 32'd0; step();
    reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic issue(input logic b, input logic [2:0] c, input logic [7:0] i, input logic [11:0] f);
    req_valid = 1'b1; req_burst = b; ev_cmd = c; ev_id = i; ev_info = f; step();
    req_valid = 1'b0; req_burst = 1'b0; ev_cmd = '0; ev_id = '0; ev_info = '0;
  endtask

  task automatic pulse_err(input logic s, input logic e, input logic [2:0] c, input logic [7:0] i, input logic [11:0] f);
    ev_serr = s; ev_inband = e; ev_cmd = c; ev_id = i; ev_info = f; step();
    ev_serr = 1'b0; ev_inband = 1'b0; ev_cmd = '0; ev_id = '0; ev_info = '0;
  endtask

  function automatic logic [63:0] exp_log(input logic [1:0] k, input logic [2:0] c, input logic [7:0] i, input logic [11:0] f);
    logic [3:0] code; logic sec; logic [12:0] fl; logic [2:0] cv; logic [11:0] fv;
    case (k)
      2'd0:    begin code = 4'h4; sec = 1'b0; fl = 13'h0; cv = 3'd0; fv = 12'h0; end
      2'd1:    begin code = 4'h5; sec = 1'b0; fl = 13'h1; cv = c;    fv = f;     end
      2'd2:    begin code = 4'h2; sec = 1'b1; fl = 13'h6; cv = c;    fv = f;     end
      default: begin code = 4'h2; sec = 1'b1; fl = 13'h2; cv = c;    fv = f;     end
    endcase
    return {3'b0, fl, 4'b0, fv, 1'b0, sec, 2'b0, code, 8'b0, i, 5'b0, cv};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_burst = 0; rsp_beat = 0; rsp_last = 0;
    ev_inband = 0; ev_serr = 0; ev_cmd = 0; ev_id = 0; ev_info = 0;
    reg_we = 0; reg_addr = 2'd3; reg_wdata = 0; to_limit = TO_W'(LIM);
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    read_log(lo, hi);
    check("R1 log", {hi, lo}, 64'h0);
    check("R1 irq/ready/flags", {60'h0, irq, flag_serr, flag_timeout, req_ready}, 64'h1);

    // R2 R3 R4 R5 vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k; logic [2:0] c; logic [7:0] i; logic [11:0] f;
      {k, c, i, f} = VEC[v];
      soft_reset();
      if (k == 2'd0)      pulse_err(1'b0, 1'b1, c, i, f);
      else if (k == 2'd1) pulse_err(1'b1, 1'b0, c, i, f);
      else begin
        issue(k == 2'd2, c, i, f);
        repeat (LIM) step();
      end
      read_log(lo, hi);
      check($sformatf("R2/R3/R4/R5 vector %0d log", v), {hi, lo}, exp_log(k, c, i, f));
      check($sformatf("R2/R3/R4 vector %0d irq", v), {63'h0, irq}, 64'h1);
    end

    // R4 boundary, R6 out of service, R9 soft reset hold and clear
    soft_reset();
    issue(1'b0, 3'd4, 8'h31, 12'h456);
    repeat (LIM-1) step();
    check("R4 one edge early", {63'h0, flag_timeout}, 64'h0);
    step();
    check("R4 on limit edge", {63'h0, flag_timeout}, 64'h1);
    check("R6 ready after timeout", {63'h0, req_ready}, 64'h0);
    read_log(lo0, hi);
    issue(1'b1, 3'd1, 8'h99, 12'h111);
    repeat (LIM+2) step();
    read_log(lo, hi);
    check("R6 request ignored", {hi, lo}, {32'h0002_0456, lo0});
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1; step();
    reg_we = 1'b0;
    check("R9 irq held while bit set", {63'h0, irq}, 64'h1);
    pulse_err(1'b1, 1'b1, 3'd2, 8'h44, 12'h222);
    read_log(lo, hi);
    check("R9 strobes ignored in hold", {hi, lo}, {32'h0002_0456, lo0});
    reg_addr = 2'd2; #1;
    check("R10 control readback", {32'h0, reg_rdata}, 64'h1);
    reg_we = 1'b1; reg_wdata = 32'd0; step();
    reg_we = 1'b0; reg_addr = 2'd3;
    check("R9 irq low after clear", {63'h0, irq}, 64'h0);
    check("R6 ready after clear", {63'h0, req_ready}, 64'h1);

    // R4 beats reload the counter, R11 single outstanding and completion
    issue(1'b1, 3'd2, 8'h21, 12'h777);
    check("R11 ready while busy", {63'h0, req_ready}, 64'h0);
    for (int b = 0; b < 3; b++) begin
      repeat (LIM-1) step();
      rsp_beat = 1'b1; step(); rsp_beat = 1'b0;
    end
    check("R4 beats keep it alive", {63'h0, irq}, 64'h0);
    rsp_beat = 1'b1; rsp_last = 1'b1; step(); rsp_beat = 1'b0; rsp_last = 1'b0;
    check("R11 ready after last", {63'h0, req_ready}, 64'h1);
    repeat (LIM+4) step();
    check("R11 no timeout after completion", {63'h0, irq}, 64'h0);

    // R7 stacked errors
    pulse_err(1'b0, 1'b1, 3'd6, 8'h21, 12'h5A5);
    pulse_err(1'b1, 1'b0, 3'd5, 8'h33, 12'h0F0);
    read_log(lo, hi);
    check("R7 first kept, multi and flag", {hi, lo}, exp_log(2'd0, 3'd6, 8'h21, 12'h5A5) | 64'h0001_0000_8000_0000);
    check("R3 serr flag output", {63'h0, flag_serr}, 64'h1);

    // R8 simultaneous errors
    soft_reset();
    pulse_err(1'b1, 1'b1, 3'd3, 8'h6C, 12'h0AB);
    read_log(lo, hi);
    check("R8 SError ranks above in-band", {hi, lo}, exp_log(2'd1, 3'd3, 8'h6C, 12'h0AB) | 64'h8000_0000);

    // R10 log writes ignored
    lo0 = lo;
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF; step();
    reg_addr = 2'd1; step();
    reg_we = 1'b0;
    read_log(lo, hi);
    check("R10 log write ignored", {hi, lo}, {32'h0001_00AB, lo0});

    // R4 largest limit
    soft_reset();
    to_limit = '1;
    issue(1'b0, 3'd1, 8'h0E, 12'h00E);
    repeat ((1 << TO_W) - 2) step();
    check("R4 max limit early", {63'h0, irq}, 64'h0);
    step();
    check("R4 max limit fires", {63'h0, flag_timeout}, 64'h1);

    // R4 limit zero disables
    soft_reset();
    to_limit = '0;
    issue(1'b0, 3'd1, 8'h0F, 12'h00F);
    repeat (40) step();
    check("R4 limit zero off", {63'h0, irq}, 64'h0);
    soft_reset();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule